// File: doc/BRIEF.md
# Charge Cycle Safety Timer

This block guards a battery charger against a charge cycle that runs too long. It counts ticks of a slow timebase while a charge is in progress. Once the time allowed for the current phase has passed, it raises a fault code and sends the host a one-cycle interrupt. The pre-charge phase, used while the battery sits below its low-voltage threshold, always gets a fixed four-hour allowance. The fast-charge phase gets a duration picked by a two-bit select input.

Any regulation loop may be active: input voltage, input current or die temperature. In that case the delivered current is probably below the programmed value, so by default the timer advances on only every second tick. This doubles the effective limit. A slowdown-enable input turns that stretching off, and a timer-enable input turns the whole supervisor off. The number of timebase ticks per hour is a parameter, so short runs can use a compressed timebase.

The controller is a four-state machine:
- IDLE: not timing.
- PRE: timing pre-charge.
- FAST: timing fast charge.
- EXPIRED: the fault is latched.

Its named transitions are:
- START_PRE and START_FAST: IDLE to PRE or FAST when charging is active and the timer is enabled.
- PROMOTE: PRE to FAST when the battery rises above the low threshold.
- ABORT: PRE or FAST to IDLE when charging stops or the timer is disabled.
- TIMEOUT: PRE or FAST to EXPIRED on the last counted tick.
- RELEASE: EXPIRED to IDLE on fault clear or when charging stops.

Top module: `chg_safety_timer`

## Requirements
- R1: While reset is asserted and right after it, `fault_o` reads 2'b00 and `irq_o` is 0.
- R2: While `bat_low_i` is 1 and the block is in pre-charge, the limit is 4 hours (4·TICKS_PER_HOUR counted ticks), whatever the value of `fast_sel_i`.
- R3: In fast charge the limit is set by `fast_sel_i`: 2'b00 gives 5 h, 2'b01 gives 8 h, 2'b10 gives 12 h and 2'b11 gives 20 h.
- R4: On the tick that completes the limit, `fault_o` becomes 2'b11 and `irq_o` goes high for exactly one clock cycle. Both change at the clock edge that samples that tick.
- R5: While `tmr_en_i` is 0, no tick is counted and no fault or interrupt can occur. Enabling the timer afterwards starts timing from zero.
- R6: While `slow_en_i` is 1 and any of `vreg_i`, `ireg_i` or `treg_i` is 1, only every second tick is counted, with the first tick of such a span skipped. A 5-hour setting then expires after 10 hours of ticks.
- R7: While `slow_en_i` is 0, every tick is counted even when a regulation flag is set.
- R8: The PROMOTE transition from pre-charge to fast charge clears the count, so fast charge is timed from zero.
- R9: When `chg_active_i` drops to 0, the count is cleared, and the next charge cycle is timed from zero.
- R10: `fault_o` stays at 2'b11 until `fault_clr_i` is pulsed or `chg_active_i` rises from 0 to 1. A fault clear while charging remains active re-arms the timer from zero.
- R11: While the fault is latched, further ticks produce no further interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle timebase tick |
| bat_low_i | input | 1 | Battery below low-voltage threshold (pre-charge) |
| chg_active_i | input | 1 | Charge cycle in progress |
| vreg_i | input | 1 | Input voltage regulation active |
| ireg_i | input | 1 | Input current regulation active |
| treg_i | input | 1 | Thermal regulation active |
| tmr_en_i | input | 1 | Safety timer enable |
| fast_sel_i | input | 2 | Fast-charge duration select |
| slow_en_i | input | 1 | Half-rate counting during regulation enable |
| fault_clr_i | input | 1 | Clears the latched fault and re-arms the timer |
| fault_o | output | 2 | Charge fault code, 2'b11 on timer expiry |
| irq_o | output | 1 | One-cycle interrupt pulse on expiry |

## Verification
The hardest case to reach is the half-rate path. The phase toggle is hidden, and only its effect on the expiry tick is visible at the ports. The bench holds a regulation flag high from the very start of a charge cycle, so the toggle begins from its cleared state. It then delivers exactly one tick fewer than twice the programmed count and checks that no fault has appeared. The following tick must raise the fault.

The pre-to-fast restart is reached in a similar way. The bench spends part of the pre-charge allowance, releases the low-battery flag, and checks that a full fast-charge count is still needed.

// File: rtl/chg_tmr_pkg.sv
package chg_tmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_FAST,
        ST_EXPIRED
    } tmr_state_t;

    localparam int unsigned PRE_HOURS = 4;
    localparam int unsigned MAX_HOURS = 20;
    localparam logic [1:0]  FAULT_NONE  = 2'b00;
    localparam logic [1:0]  FAULT_TIMER = 2'b11;

    function automatic int unsigned fast_hours(input logic [1:0] sel);
        int unsigned h;
        unique case (sel)
            2'b00: h = 5;
            2'b01: h = 8;
            2'b10: h = 12;
            2'b11: h = 20;
            default: h = 5;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/chg_tmr_rate.sv
module chg_tmr_rate (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    input  logic reg_any_i,
    input  logic slow_en_i,
    output logic adv_o
);

    logic gated;
    logic ph_q;

    assign gated = slow_en_i && reg_any_i;
    assign adv_o = tick_i && (!gated || ph_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= 1'b0;
        end else if (clr_i || !gated) begin
            ph_q <= 1'b0;
        end else if (tick_i) begin
            ph_q <= ~ph_q;
        end
    end

    AST_ADV_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |-> tick_i);  // R6

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !slow_en_i) |-> adv_o);  // R7

endmodule

// File: rtl/chg_tmr_count.sv
module chg_tmr_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic          adv_i,
    input  logic [CW-1:0] limit_i,
    output logic          hit_o
);

    logic [CW-1:0] cnt_q;
    logic [CW:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
    assign hit_o   = run_i && adv_i && (cnt_nxt >= {1'b0, limit_i});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && adv_i) begin
            cnt_q <= cnt_nxt[CW-1:0];
        end
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));  // R9

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clr_i && !adv_i) |=> $stable(cnt_q));  // R6

endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer
    import chg_tmr_pkg::*;
#(
    parameter int TICKS_PER_HOUR = 3600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       bat_low_i,
    input  logic       chg_active_i,
    input  logic       vreg_i,
    input  logic       ireg_i,
    input  logic       treg_i,
    input  logic       tmr_en_i,
    input  logic [1:0] fast_sel_i,
    input  logic       slow_en_i,
    input  logic       fault_clr_i,
    output logic [1:0] fault_o,
    output logic       irq_o
);

    localparam int MAX_LIM = MAX_HOURS * TICKS_PER_HOUR;
    localparam int CW      = $clog2(MAX_LIM + 1);
    localparam logic [CW-1:0] PRE_LIM = CW'(PRE_HOURS * TICKS_PER_HOUR);

    tmr_state_t    st_q, st_nxt;
    logic [CW-1:0] lim_tab [4];
    logic [CW-1:0] limit;
    logic          run, clr, adv, hit, reg_any;
    logic          act_q, irq_q;
    logic [1:0]    fault_q;

    for (genvar g = 0; g < 4; g++) begin : g_lim
        assign lim_tab[g] = CW'(fast_hours(2'(g)) * TICKS_PER_HOUR);
    end

    assign reg_any = vreg_i || ireg_i || treg_i;
    assign run     = (st_q == ST_PRE) || (st_q == ST_FAST);
    assign clr     = !run || (st_nxt != st_q);
    assign limit   = (st_q == ST_PRE) ? PRE_LIM : lim_tab[fast_sel_i];

    chg_tmr_rate i_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .tick_i    (tick_i),
        .reg_any_i (reg_any),
        .slow_en_i (slow_en_i),
        .adv_o     (adv)
    );

    chg_tmr_count #(.CW(CW)) i_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .run_i   (run),
        .adv_i   (adv),
        .limit_i (limit),
        .hit_o   (hit)
    );

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (chg_active_i && tmr_en_i)
                    st_nxt = bat_low_i ? ST_PRE : ST_FAST;   // START_PRE / START_FAST
            end
            ST_PRE: begin
                if (!chg_active_i || !tmr_en_i) st_nxt = ST_IDLE;     // ABORT
                else if (hit)                   st_nxt = ST_EXPIRED;  // TIMEOUT
                else if (!bat_low_i)            st_nxt = ST_FAST;     // PROMOTE
            end
            ST_FAST: begin
                if (!chg_active_i || !tmr_en_i) st_nxt = ST_IDLE;     // ABORT
                else if (hit)                   st_nxt = ST_EXPIRED;  // TIMEOUT
            end
            ST_EXPIRED: begin
                if (fault_clr_i || !chg_active_i) st_nxt = ST_IDLE;   // RELEASE
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            irq_q   <= 1'b0;
            fault_q <= FAULT_NONE;
        end else begin
            act_q <= chg_active_i;
            irq_q <= (st_nxt == ST_EXPIRED) && (st_q != ST_EXPIRED);
            if ((st_nxt == ST_EXPIRED) && (st_q != ST_EXPIRED))
                fault_q <= FAULT_TIMER;
            else if (fault_clr_i || (chg_active_i && !act_q))
                fault_q <= FAULT_NONE;
        end
    end

    assign fault_o = fault_q;
    assign irq_o   = irq_q;

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);  // R4

    AST_IRQ_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (fault_o == FAULT_TIMER));  // R4

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en_i |=> !irq_o);  // R5

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_o == FAULT_TIMER) && !fault_clr_i && !(chg_active_i && !act_q))
        |=> (fault_o == FAULT_TIMER));  // R10

    AST_NO_REPEAT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXPIRED) |=> !irq_o);  // R11

endmodule

// File: tb/test_chg_safety_timer.sv
module test_chg_safety_timer;

    localparam int CLK_PERIOD = 10;
    localparam int TPH        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bat_low = 1'b0;
    logic       chg_active = 1'b0;
    logic       vreg = 1'b0;
    logic       ireg = 1'b0;
    logic       treg = 1'b0;
    logic       tmr_en = 1'b1;
    logic [1:0] fast_sel = 2'b00;
    logic       slow_en = 1'b1;
    logic       fault_clr = 1'b0;
    logic [1:0] fault;
    logic       irq;

    int errors = 0;
    int checks = 0;
    int irq_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_safety_timer #(.TICKS_PER_HOUR(TPH)) i_chg_safety_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .bat_low_i    (bat_low),
        .chg_active_i (chg_active),
        .vreg_i       (vreg),
        .ireg_i       (ireg),
        .treg_i       (treg),
        .tmr_en_i     (tmr_en),
        .fast_sel_i   (fast_sel),
        .slow_en_i    (slow_en),
        .fault_clr_i  (fault_clr),
        .fault_o      (fault),
        .irq_o        (irq)
    );

    always @(negedge clk) if (rst_n && irq) irq_seen++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic start_cycle(input logic low, input logic [1:0] sel,
                               input logic slow, input logic [2:0] regs);
        @(negedge clk) chg_active = 1'b0;
        @(negedge clk);
        bat_low = low; fast_sel = sel; slow_en = slow;
        {vreg, ireg, treg} = regs; tmr_en = 1'b1;
        @(negedge clk) chg_active = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // n-1 ticks leave no fault; tick n raises fault and a one-cycle irq
    task automatic expire_at(input int n, input string req);
        ticks(n - 1);
        chk(fault == 2'b00, req, fault, 0);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        chk(irq == 1'b1 && fault == 2'b11, req, {irq, fault}, 7);
        @(negedge clk);
        chk(irq == 1'b0, {req, " irq one cycle"}, irq, 0);
    endtask

    task automatic t_reset();
        chk(fault == 2'b00 && irq == 1'b0, "R1 in reset", {irq, fault}, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(fault == 2'b00 && irq == 1'b0, "R1 after reset", {irq, fault}, 0);
    endtask

    task automatic t_pre_fixed();
        start_cycle(1'b1, 2'b11, 1'b1, 3'b000);
        expire_at(4 * TPH, "R2 pre-charge 4h");
    endtask

    task automatic t_fast_sel();
        start_cycle(1'b0, 2'b00, 1'b1, 3'b000);
        expire_at(5 * TPH, "R3 sel00 5h / R4");
        start_cycle(1'b0, 2'b01, 1'b1, 3'b000);
        expire_at(8 * TPH, "R3 sel01 8h");
        start_cycle(1'b0, 2'b10, 1'b1, 3'b000);
        expire_at(12 * TPH, "R3 sel10 12h");
        start_cycle(1'b0, 2'b11, 1'b1, 3'b000);
        expire_at(20 * TPH, "R3 sel11 20h");
    endtask

    task automatic t_disabled();
        start_cycle(1'b0, 2'b00, 1'b1, 3'b000);
        @(negedge clk) tmr_en = 1'b0;
        irq_seen = 0;
        ticks(30);
        chk(fault == 2'b00 && irq_seen == 0, "R5 disabled", irq_seen + fault, 0);
        @(negedge clk) tmr_en = 1'b1;
        @(negedge clk);
        expire_at(5 * TPH, "R5 re-enable from zero");
    endtask

    task automatic t_half_rate();
        start_cycle(1'b0, 2'b00, 1'b1, 3'b010);
        expire_at(10 * TPH, "R6 ireg half rate");
        start_cycle(1'b0, 2'b00, 1'b1, 3'b100);
        expire_at(10 * TPH, "R6 vreg half rate");
        {vreg, ireg, treg} = 3'b000;
    endtask

    task automatic t_full_rate();
        start_cycle(1'b0, 2'b00, 1'b0, 3'b001);
        expire_at(5 * TPH, "R7 slowdown off");
        {vreg, ireg, treg} = 3'b000;
        slow_en = 1'b1;
    endtask

    task automatic t_promote();
        start_cycle(1'b1, 2'b00, 1'b1, 3'b000);
        ticks(10);
        @(negedge clk) bat_low = 1'b0;
        @(negedge clk);
        expire_at(5 * TPH, "R8 fast restarts at zero");
    endtask

    task automatic t_inactive();
        start_cycle(1'b0, 2'b00, 1'b1, 3'b000);
        ticks(15);
        start_cycle(1'b0, 2'b00, 1'b1, 3'b000);
        expire_at(5 * TPH, "R9 new cycle from zero");
    endtask

    task automatic t_fault_release();
        start_cycle(1'b0, 2'b00, 1'b1, 3'b000);
        expire_at(5 * TPH, "R10 setup");
        ticks(3);
        chk(fault == 2'b11, "R10 fault held", fault, 3);
        @(negedge clk) fault_clr = 1'b1;
        @(negedge clk) fault_clr = 1'b0;
        chk(fault == 2'b00, "R10 fault_clr", fault, 0);
        @(negedge clk);
        expire_at(5 * TPH, "R10 re-armed from zero");
        @(negedge clk) chg_active = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(fault == 2'b11, "R10 held while inactive", fault, 3);
        @(negedge clk) chg_active = 1'b1;
        @(negedge clk);
        chk(fault == 2'b00, "R10 cleared by new cycle", fault, 0);
    endtask

    task automatic t_no_repeat();
        start_cycle(1'b0, 2'b00, 1'b1, 3'b000);
        expire_at(5 * TPH, "R11 setup");
        irq_seen = 0;
        ticks(25);
        chk(irq_seen == 0 && fault == 2'b11, "R11 single pulse", irq_seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_pre_fixed();
        t_fast_sel();
        t_disabled();
        t_half_rate();
        t_full_rate();
        t_promote();
        t_inactive();
        t_fault_release();
        t_no_repeat();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule